// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block applies per-channel colour gamma correction for a compositor that drives three output channels. Every channel has its own curve for each of the red, green and blue components, so the table holds 768 eight-bit entries per channel and 2304 entries in all. The table is one linear address space, and channel 0 sits at the bottom. Inside a channel the red curve comes first, then the green curve, then the blue curve. The curve entry for pixel value `v` of colour `c` on channel `n` therefore lives at linear address `n*768 + c*256 + v`.

A host loads the table through two registers behind a one-cycle write strobe. One is a pointer register with an auto-increment flag. The other is a data port that stores the low byte of each write at the pointer. This lets a whole channel be streamed in with one pointer write followed by 768 data writes. On the pixel side, each valid input carries an 8-bit R, G and B value and a channel number. The corrected triple comes out two cycles later with its own valid flag.

Each channel has its own gamma enable. When a channel's enable is clear, its pixels pass through unchanged, which is the same as a linear curve. When every enable is clear at once, the table storage counts as powered down and data writes are dropped. The host reloads the table after enabling a channel. The table is not double buffered, so a channel that is reloaded while live may briefly mix old and new entries.

Top module: `gamma_lut`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_r`, `out_g`, `out_b` are 0. After reset the pointer is 0 with auto-increment off, so data writes land on entry 0.
- R2: With channel `n` in range and its enable set, each output component of colour `c` equals the table entry at linear address `n*768 + c*256 + v`, where `v` is that input component and the colour codes are red 0, green 1, blue 2.
- R3: A write with `host_sel` = 0 loads the pointer from `host_wdata[11:0]` and the auto-increment flag from `host_wdata[15]`. A pointer value of 2304 or more loads as 0.
- R4: With auto-increment off, a data write (`host_sel` = 1) leaves the pointer unchanged, so repeated writes overwrite the same entry.
- R5: With auto-increment on, each data write advances the pointer by one, and a data write at entry 2303 moves the pointer to 0.
- R6: For a channel whose bit of `gamma_en` is 0, each output component equals the matching input component.
- R7: A pixel whose channel number is 3 or more passes through unchanged, whatever `gamma_en` holds.
- R8: `out_valid` is high exactly two cycles after `pix_valid` was high. `gamma_en` is sampled in the same cycle as the pixel, and the output components hold their last value while `out_valid` is low.
- R9: While every bit of `gamma_en` is 0, data writes leave the table unchanged, but the pointer still advances as R4 and R5 describe.
- R10: Only `host_wdata[7:0]` of a data write is stored, and bits 15:8 have no effect on the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe, one write per cycle |
| host_sel | input | 1 | 0 selects the pointer register, 1 the data port |
| host_wdata | input | 16 | Host write data; pointer in [11:0], auto-increment in [15], entry in [7:0] |
| gamma_en | input | 3 | Per-channel gamma enable, bit n for channel n |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | 2 | Channel number of the input pixel |
| pix_r | input | 8 | Input red component |
| pix_g | input | 8 | Input green component |
| pix_b | input | 8 | Input blue component |
| out_valid | output | 1 | Corrected pixel valid, two cycles after input |
| out_r | output | 8 | Corrected red component |
| out_g | output | 8 | Corrected green component |
| out_b | output | 8 | Corrected blue component |

## Verification
The table is filled with random bytes through one auto-incrementing pass. Random pixel streams with gaps in `pix_valid` then run with all channels enabled, which checks the three-part address layout and the two-cycle alignment of data and valid. A second set of streams runs with mixed enable patterns and includes channel number 3, which separates table lookups from bypassed pixels within a single stream. Directed host sequences cover the rest: a non-incrementing pointer, an out-of-range pointer load, the wrap from the last entry, data bits above the byte, and writes issued while every channel is disabled. Each of these is read back through the pixel path.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  localparam int GL_NUM_CH  = 3;
  localparam int GL_PIX_W   = 8;
  localparam int GL_HOST_W  = 16;
  localparam int GL_ADDR_W  = 12;
  localparam int GL_NUM_COL = 3;

  typedef enum logic [1:0] {
    COL_RED   = 2'd0,
    COL_GREEN = 2'd1,
    COL_BLUE  = 2'd2
  } colour_e;
endpackage

// File: rtl/gamma_lut_host.sv
module gamma_lut_host
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = GL_NUM_CH,
  parameter int PIX_W  = GL_PIX_W,
  parameter int HOST_W = GL_HOST_W,
  parameter int ADDR_W = GL_ADDR_W,
  localparam int PER_COL = 1 << PIX_W,
  localparam int PER_CH  = GL_NUM_COL * PER_COL,
  localparam int DEPTH   = NUM_CH * PER_CH,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BANK_AW = CH_W + PIX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_sel,
  input  logic [HOST_W-1:0]  host_wdata,
  input  logic               all_off,
  output logic               wr_en,
  output logic [1:0]         wr_col,
  output logic [BANK_AW-1:0] wr_baddr,
  output logic [PIX_W-1:0]   wr_data,
  output logic [ADDR_W-1:0]  ptr,
  output logic               autoinc
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, ld_val, ch_full, rem_full;
  logic              ai_q, ai_d;
  logic              unused_bits;

  // next state of pointer and increment flag
  always_comb begin
    ld_val = host_wdata[ADDR_W-1:0];
    ptr_d  = ptr_q;
    ai_d   = ai_q;
    if (host_wr && !host_sel) begin
      ptr_d = (ld_val >= ADDR_W'(DEPTH)) ? '0 : ld_val;
      ai_d  = host_wdata[HOST_W-1];
    end else if (host_wr && host_sel && ai_q) begin
      ptr_d = (ptr_q == ADDR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ai_q  <= 1'b0;
    end else if (host_wr) begin
      ptr_q <= ptr_d;
      ai_q  <= ai_d;
    end
  end

  // split linear pointer into channel, colour and index
  always_comb begin
    ch_full  = ptr_q / ADDR_W'(PER_CH);
    rem_full = ptr_q - ch_full * ADDR_W'(PER_CH);
    wr_col   = rem_full[PIX_W+1:PIX_W];
    wr_baddr = {ch_full[CH_W-1:0], rem_full[PIX_W-1:0]};
    wr_data  = host_wdata[PIX_W-1:0];
    wr_en    = host_wr && host_sel && !all_off;
  end

  assign unused_bits = ^{host_wdata[HOST_W-2:ADDR_W], ch_full[ADDR_W-1:CH_W],
                         rem_full[ADDR_W-1:PIX_W+2]};
  assign ptr     = ptr_q;
  assign autoinc = ai_q;
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
  parameter int DEPTH = 768,
  parameter int AW    = 10,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/gamma_lut_pipe.sv
module gamma_lut_pipe
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = GL_NUM_CH,
  parameter int PIX_W  = GL_PIX_W,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TRI_W = GL_NUM_COL * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [CH_W-1:0]   pix_ch,
  input  logic [TRI_W-1:0]  pix_in,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic [TRI_W-1:0]  rd_data,
  output logic              rd_en,
  output logic              out_valid,
  output logic [TRI_W-1:0]  out_pix
);
  logic             in_range, en_sel, byp_d;
  logic             v1_q, byp1_q, ov_q;
  logic [TRI_W-1:0] raw1_q, out_q, out_d;

  always_comb begin
    in_range = {1'b0, pix_ch} < (CH_W + 1)'(NUM_CH);
    en_sel   = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (pix_ch == CH_W'(c)) en_sel = gamma_en[c];
    end
    rd_en = pix_valid && in_range && en_sel;
    byp_d = !(in_range && en_sel);
    out_d = byp1_q ? raw1_q : rd_data;
  end

  // stage 1: table read in flight, raw pixel held beside it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      byp1_q <= 1'b0;
      raw1_q <= '0;
    end else begin
      v1_q <= pix_valid;
      if (pix_valid) begin
        byp1_q <= byp_d;
        raw1_q <= pix_in;
      end
    end
  end

  // stage 2: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      out_q <= '0;
    end else begin
      ov_q <= v1_q;
      if (v1_q) out_q <= out_d;
    end
  end

  assign out_valid = ov_q;
  assign out_pix   = out_q;
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int NUM_CH = GL_NUM_CH,
  parameter int PIX_W  = GL_PIX_W,
  parameter int HOST_W = GL_HOST_W,
  parameter int ADDR_W = GL_ADDR_W,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BANK_AW = CH_W + PIX_W,
  localparam int BANK_D  = NUM_CH << PIX_W,
  localparam int TRI_W   = GL_NUM_COL * PIX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  input  logic [NUM_CH-1:0] gamma_en,
  input  logic              pix_valid,
  input  logic [CH_W-1:0]   pix_ch,
  input  logic [PIX_W-1:0]  pix_r,
  input  logic [PIX_W-1:0]  pix_g,
  input  logic [PIX_W-1:0]  pix_b,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_r,
  output logic [PIX_W-1:0]  out_g,
  output logic [PIX_W-1:0]  out_b
);
  logic               wr_en, autoinc, rd_en, all_off;
  logic [1:0]         wr_col;
  logic [BANK_AW-1:0] wr_baddr;
  logic [PIX_W-1:0]   wr_data;
  logic [ADDR_W-1:0]  ptr;
  logic [TRI_W-1:0]   pix_in, rd_data, out_pix;

  assign all_off = ~|gamma_en;
  assign pix_in  = {pix_b, pix_g, pix_r};

  gamma_lut_host #(
    .NUM_CH(NUM_CH), .PIX_W(PIX_W), .HOST_W(HOST_W), .ADDR_W(ADDR_W)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .all_off(all_off), .wr_en(wr_en),
    .wr_col(wr_col), .wr_baddr(wr_baddr), .wr_data(wr_data),
    .ptr(ptr), .autoinc(autoinc)
  );

  for (genvar c = 0; c < GL_NUM_COL; c++) begin : g_bank
    gamma_lut_bank #(.DEPTH(BANK_D), .AW(BANK_AW), .DW(PIX_W)) u_bank (
      .clk(clk),
      .we(wr_en && (wr_col == 2'(c))),
      .waddr(wr_baddr),
      .wdata(wr_data),
      .re(rd_en),
      .raddr({pix_ch, pix_in[c*PIX_W +: PIX_W]}),
      .rdata(rd_data[c*PIX_W +: PIX_W])
    );
  end

  gamma_lut_pipe #(.NUM_CH(NUM_CH), .PIX_W(PIX_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ch(pix_ch),
    .pix_in(pix_in), .gamma_en(gamma_en), .rd_data(rd_data),
    .rd_en(rd_en), .out_valid(out_valid), .out_pix(out_pix)
  );

  assign out_r = out_pix[0 +: PIX_W];
  assign out_g = out_pix[PIX_W +: PIX_W];
  assign out_b = out_pix[2*PIX_W +: PIX_W];
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int NUM_CH = 3,
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DEPTH = NUM_CH * 3 * (1 << PIX_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_sel,
  input logic [NUM_CH-1:0] gamma_en,
  input logic              pix_valid,
  input logic [CH_W-1:0]   pix_ch,
  input logic [PIX_W-1:0]  pix_r,
  input logic [PIX_W-1:0]  pix_g,
  input logic [PIX_W-1:0]  pix_b,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_r,
  input logic [PIX_W-1:0]  out_g,
  input logic [PIX_W-1:0]  out_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] ptr,
  input logic              autoinc
);
  logic off_chan, dis_chan;

  always_comb begin
    off_chan = !({1'b0, pix_ch} < (CH_W + 1)'(NUM_CH));
    dis_chan = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (pix_ch == CH_W'(c)) dis_chan = !gamma_en[c];
    end
  end

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(pix_valid, 2));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(dis_chan, 2)) |->
      (out_r == $past(pix_r, 2) && out_g == $past(pix_g, 2) && out_b == $past(pix_b, 2)));

  p_offchan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(off_chan, 2)) |->
      (out_r == $past(pix_r, 2) && out_g == $past(pix_g, 2) && out_b == $past(pix_b, 2)));

  p_dropwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gamma_en == '0) |-> !wr_en);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && autoinc && ptr == ADDR_W'(DEPTH - 1)) |=> (ptr == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && !autoinc) |=> $stable(ptr));

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < ADDR_W'(DEPTH));
endmodule

bind gamma_lut gamma_lut_chk #(.NUM_CH(NUM_CH), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .gamma_en(gamma_en), .pix_valid(pix_valid), .pix_ch(pix_ch),
  .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid),
  .out_r(out_r), .out_g(out_g), .out_b(out_b), .wr_en(wr_en),
  .ptr(ptr), .autoinc(autoinc)
);

// File: tb/tb_gamma_lut.sv
module tb_gamma_lut;
  localparam int DEPTH = 2304;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_sel;
  logic [15:0] host_wdata;
  logic [2:0]  gamma_en;
  logic        pix_valid;
  logic [1:0]  pix_ch;
  logic [7:0]  pix_r, pix_g, pix_b;
  logic        out_valid;
  logic [7:0]  out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;
  logic [7:0] tbl [DEPTH];
  int m_ptr;
  bit m_ai;

  always #10 clk = ~clk;

  gamma_lut dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .gamma_en(gamma_en), .pix_valid(pix_valid),
    .pix_ch(pix_ch), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expv(input int ch, input int col,
                                      input logic [7:0] v, input logic [2:0] en);
    if (ch < 3 && en[ch]) return tbl[ch*768 + col*256 + int'(v)];
    return v;
  endfunction

  task automatic host_addr(input logic [15:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_sel = 1'b0; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
    m_ptr = (int'(v[11:0]) >= DEPTH) ? 0 : int'(v[11:0]);
    m_ai  = v[15];
  endtask

  task automatic host_data(input logic [15:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_sel = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
    if (gamma_en != 3'b000) tbl[m_ptr] = v[7:0];
    if (m_ai) m_ptr = (m_ptr == DEPTH-1) ? 0 : m_ptr + 1;
  endtask

  task automatic look(input int ch, input logic [7:0] r, input logic [7:0] g,
                      input logic [7:0] b, input string req, output logic [23:0] got);
    logic [23:0] e;
    @(negedge clk);
    pix_valid = 1'b1; pix_ch = 2'(ch); pix_r = r; pix_g = g; pix_b = b;
    e = {expv(ch, 0, r, gamma_en), expv(ch, 1, g, gamma_en), expv(ch, 2, b, gamma_en)};
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    got = {out_r, out_g, out_b};
    chk(out_valid === 1'b1, "R8", "out_valid after lookup", int'(out_valid), 1);
    chk(got === e, req, "lookup triple", int'(got), int'(e));
  endtask

  task automatic stream(input int n, input int maxch, input logic [2:0] en, input string req);
    logic        e1v, e2v, v;
    logic [23:0] e1, e2;
    logic [7:0]  r, g, b;
    int          ch;
    gamma_en = en;
    e1v = 1'b0; e2v = 1'b0; e1 = '0; e2 = '0;
    for (int k = 0; k < n + 2; k++) begin
      @(negedge clk);
      chk(out_valid === e2v, "R8", "stream out_valid", int'(out_valid), int'(e2v));
      if (e2v) chk({out_r, out_g, out_b} === e2, req, "stream triple",
                   int'({out_r, out_g, out_b}), int'(e2));
      e2v = e1v; e2 = e1;
      if (k < n) begin
        v  = ($urandom % 4) != 0;
        ch = int'($urandom % (maxch + 1));
        r = 8'($urandom); g = 8'($urandom); b = 8'($urandom);
        pix_valid = v; pix_ch = 2'(ch); pix_r = r; pix_g = g; pix_b = b;
        e1v = v;
        e1  = {expv(ch, 0, r, en), expv(ch, 1, g, en), expv(ch, 2, b, en)};
      end else begin
        pix_valid = 1'b0;
        e1v = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] got;
    logic [7:0]  old;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; host_wr = 1'b0; host_sel = 1'b0; host_wdata = '0;
    gamma_en = 3'b111; pix_valid = 1'b0; pix_ch = '0;
    pix_r = '0; pix_g = '0; pix_b = '0;
    m_ptr = 0; m_ai = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk({out_r, out_g, out_b} === 24'h0, "R1", "outputs in reset",
        int'({out_r, out_g, out_b}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // R1: pointer 0, no increment after reset: second write overwrites entry 0
    host_data(16'h0077);
    host_data(16'h0078);
    look(0, 8'd0, 8'd0, 8'd0, "R1", got);
    chk(got[23:16] === 8'h78, "R1", "entry 0 after reset writes", int'(got[23:16]), 'h78);

    // full random load, auto-increment
    host_addr(16'h8000);
    for (int i = 0; i < DEPTH; i++) host_data({8'h00, 8'($urandom)});
    chk(m_ptr == 0, "R5", "model pointer wrapped after full load", m_ptr, 0);

    // R2 R8: all channels enabled
    stream(300, 2, 3'b111, "R2");
    look(2, 8'd3, 8'd4, 8'd5, "R2", got);

    // R6 R7: mixed enables and out-of-range channel
    stream(200, 3, 3'b101, "R6");
    stream(200, 3, 3'b010, "R7");
    gamma_en = 3'b111;
    look(3, 8'h12, 8'h34, 8'h56, "R7", got);
    chk(got === 24'h123456, "R7", "channel 3 passthrough", int'(got), 'h123456);

    // R4: no auto-increment keeps pointer
    host_addr(16'd1034);
    host_data(16'h0011);
    host_data(16'h0022);
    look(1, 8'd5, 8'd10, 8'd7, "R4", got);
    chk(got[15:8] === 8'h22, "R4", "repeated write same entry", int'(got[15:8]), 'h22);
    look(1, 8'd5, 8'd11, 8'd7, "R4", got);

    // R3: out-of-range pointer loads 0
    host_addr(16'h8000 | 16'd4000);
    host_data(16'h005A);
    look(0, 8'd0, 8'd1, 8'd2, "R3", got);
    chk(got[23:16] === 8'h5A, "R3", "pointer clamped to 0", int'(got[23:16]), 'h5A);

    // R5: wrap from last entry
    host_addr(16'h8000 | 16'd2303);
    host_data(16'h00A1);
    host_data(16'h00B2);
    look(2, 8'd9, 8'd9, 8'd255, "R5", got);
    chk(got[7:0] === 8'hA1, "R5", "last entry", int'(got[7:0]), 'hA1);
    look(0, 8'd0, 8'd9, 8'd9, "R5", got);
    chk(got[23:16] === 8'hB2, "R5", "wrapped to entry 0", int'(got[23:16]), 'hB2);

    // R10: upper data bits ignored
    host_addr(16'h8000 | 16'd5);
    host_data(16'hFF3C);
    look(0, 8'd5, 8'd0, 8'd0, "R10", got);
    chk(got[23:16] === 8'h3C, "R10", "low byte stored", int'(got[23:16]), 'h3C);

    // R9: writes dropped while all enables clear, pointer still advances
    old = tbl[100];
    gamma_en = 3'b000;
    host_addr(16'h8000 | 16'd100);
    host_data(16'h00EE);
    gamma_en = 3'b001;
    host_data(16'h0044);
    look(0, 8'd100, 8'd0, 8'd0, "R9", got);
    chk(got[23:16] === old, "R9", "dropped write left entry", int'(got[23:16]), int'(old));
    look(0, 8'd101, 8'd0, 8'd0, "R9", got);
    chk(got[23:16] === 8'h44, "R9", "pointer advanced past dropped write",
        int'(got[23:16]), 'h44);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule